// File: doc/BRIEF.md
# Two-Byte Sampling Converter Read Sequencer

This block sits on the host side of a 12-bit sampling converter that shares an 8-bit data bus. On a single-cycle request it selects the converter, holds the selection for a programmable setup window, then pulls the read/convert line low for a programmable pulse so that read/convert is the last control to arrive and therefore owns the start edge. The byte address line is held low across that edge, which makes the converter run a full 12-bit conversion.

The sequencer then watches the converter's busy flag through a synchronizer. It waits for the flag to rise and then to fall, and it does not touch the bus while the flag is high. Once the flag is low it reads two bytes. With the address low it takes the upper eight result bits. With the address high it takes the bottom four result bits, which sit in the upper nibble of that byte; the lower nibble is zero padding and is discarded. The two reads are joined into a left-justified 12-bit word and presented with a one-cycle done pulse.

If the flag fails to rise and fall within a programmable budget, the sequencer abandons the transfer. It pulses a timeout flag and returns to idle. The word-length select output stays low at all times, so the converter always delivers its result as two bytes.

Top module: `adc_byte_reader`

## Requirements
- R1: Out of reset, and whenever no transfer is running, chip_en_o is 0, chip_sel_n_o is 1, read_mode_o is 1, byte_addr_o is 0, and done_o and timeout_o are 0.
- R2: read_mode_o falls only while chip_en_o=1 and chip_sel_n_o=0. Both have been in that state, with read_mode_o high, for at least SETUP_CYC consecutive cycles before the fall. read_mode_o then stays low for PULSE_CYC cycles.
- R3: byte_addr_o is 0 in the cycle read_mode_o falls, and it never changes while conv_busy_i is high.
- R4: word_mode_o is 0 in every cycle.
- R5: The bus is not sampled while the synchronized busy flag is high. The first read, taken with byte_addr_o=0, supplies result_o[11:4] from data_bus_i[7:0].
- R6: The second read, taken with byte_addr_o=1, supplies result_o[3:0] from data_bus_i[7:4]. data_bus_i[3:0] of that byte has no effect on result_o.
- R7: Each read holds its address with read_mode_o=1, chip_en_o=1 and chip_sel_n_o=0 for ACCESS_CYC cycles and samples on the last of them. done_o therefore rises SYNC_STAGES+1+2*ACCESS_CYC cycles after conv_busy_i falls.
- R8: done_o is high for exactly one cycle per completed transfer. result_o is valid in that cycle and holds its value until the next transfer overwrites it.
- R9: start_req_i is acted on only in idle. A request that arrives while a transfer is running starts no further conversion.
- R10: If the busy flag does not both rise and fall within TIMEOUT_CYC cycles of the end of the convert pulse, timeout_o pulses for one cycle, done_o stays low, and the block returns to the idle state of R1, ready for a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req_i | input | 1 | Request one conversion and read-back |
| conv_busy_i | input | 1 | Converter busy flag, high during conversion (asynchronous) |
| data_bus_i | input | 8 | Shared 8-bit data bus from the converter |
| chip_en_o | output | 1 | Converter enable, active high |
| chip_sel_n_o | output | 1 | Converter select, active low |
| read_mode_o | output | 1 | High selects read, falling edge starts a conversion |
| word_mode_o | output | 1 | Output word width select, held low (two-byte mode) |
| byte_addr_o | output | 1 | Byte address: 0 = upper byte, 1 = lower nibble byte |
| result_o | output | 12 | Assembled left-justified conversion result |
| done_o | output | 1 | One-cycle pulse, result_o valid |
| timeout_o | output | 1 | One-cycle pulse, busy flag did not complete in time |

## Verification
Transfers are run with the codes 000, FFF, 800, 5A3 and 3C6 (hex). Each code is paired with a different value in the padding nibble of the second byte. An all-zero or all-ones code shows a stuck or swapped byte lane, a lone MSB shows bit order, and the non-zero padding shows whether the padding leaks into result_o. While busy is high the converter model drives a fixed junk byte, so any sample taken before the flag falls produces a wrong result. The model also measures the setup run before each start edge and the A0 level at that edge. A repeated request during a conversion and the two busy-flag faults, never rising and never falling, separate the ignore, timeout and recovery behaviour.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

    localparam int unsigned RES_W  = 12;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LO_W   = RES_W - BYTE_W;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_SETUP   = 4'd1,
        ST_CONV    = 4'd2,
        ST_WAIT_HI = 4'd3,
        ST_WAIT_LO = 4'd4,
        ST_RD_HI   = 4'd5,
        ST_RD_LO   = 4'd6,
        ST_DONE    = 4'd7,
        ST_ERR     = 4'd8
    } rd_state_e;

    typedef struct packed {
        logic en;
        logic sel_n;
        logic rdconv;
        logic addr;
    } bus_ctrl_t;

    localparam bus_ctrl_t CTRL_IDLE = '{en: 1'b0, sel_n: 1'b1, rdconv: 1'b1, addr: 1'b0};

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic bus_ctrl_t ctrl_for(input rd_state_e s);
        bus_ctrl_t c;
        c = '{en: 1'b1, sel_n: 1'b0, rdconv: 1'b1, addr: 1'b0};
        case (s)
            ST_IDLE, ST_DONE, ST_ERR: c = CTRL_IDLE;
            ST_CONV:                  c.rdconv = 1'b0;
            ST_RD_LO:                 c.addr = 1'b1;
            default:                  ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rd_sync.sv
`timescale 1ns/1ps
module rd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr <= '0;
                end else begin
                    sr[0] <= d_i;
                    for (int i = 1; i < int'(STAGES); i++) begin
                        sr[i] <= sr[i-1];
                    end
                end
            end
            assign q_o = sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rd_timer.sv
`timescale 1ns/1ps
module rd_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rd_ctrl_fsm.sv
`timescale 1ns/1ps
module rd_ctrl_fsm
    import adc_rd_pkg::*;
#(
    parameter int unsigned SETUP_CYC   = 10,
    parameter int unsigned PULSE_CYC   = 4,
    parameter int unsigned ACCESS_CYC  = 3,
    parameter int unsigned TIMEOUT_CYC = 4000,
    parameter int unsigned CW          = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          busy_s_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_val_o,
    output bus_ctrl_t     ctrl_o,
    output logic          cap_hi_o,
    output logic          cap_lo_o,
    output logic          done_o,
    output logic          err_o
);
    localparam logic [CW-1:0] SETUP_LD   = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] PULSE_LD   = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] ACCESS_LD  = CW'(ACCESS_CYC - 1);
    localparam logic [CW-1:0] TIMEOUT_LD = CW'(TIMEOUT_CYC - 1);

    rd_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d       = st_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        cap_hi_o   = 1'b0;
        cap_lo_o   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d       = ST_SETUP;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = SETUP_LD;
                end
            end
            ST_SETUP: begin
                if (tmr_zero_i) begin
                    st_d       = ST_CONV;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = PULSE_LD;
                end
            end
            ST_CONV: begin
                if (tmr_zero_i) begin
                    st_d       = ST_WAIT_HI;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TIMEOUT_LD;
                end
            end
            ST_WAIT_HI: begin
                if (busy_s_i)        st_d = ST_WAIT_LO;
                else if (tmr_zero_i) st_d = ST_ERR;
            end
            ST_WAIT_LO: begin
                if (!busy_s_i) begin
                    st_d       = ST_RD_HI;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = ACCESS_LD;
                end else if (tmr_zero_i) begin
                    st_d = ST_ERR;
                end
            end
            ST_RD_HI: begin
                if (tmr_zero_i) begin
                    cap_hi_o   = 1'b1;
                    st_d       = ST_RD_LO;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = ACCESS_LD;
                end
            end
            ST_RD_LO: begin
                if (tmr_zero_i) begin
                    cap_lo_o = 1'b1;
                    st_d     = ST_DONE;
                end
            end
            ST_DONE: st_d = ST_IDLE;
            ST_ERR:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign ctrl_o = ctrl_for(st_q);
    assign done_o = (st_q == ST_DONE);
    assign err_o  = (st_q == ST_ERR);
endmodule

// File: rtl/rd_word_pack.sv
`timescale 1ns/1ps
module rd_word_pack
    import adc_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_hi_i,
    input  logic              cap_lo_i,
    input  logic [BYTE_W-1:0] bus_i,
    output logic [RES_W-1:0]  word_o
);
    logic [BYTE_W-1:0] hi_q;
    logic [LO_W-1:0]   lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (cap_hi_i) hi_q <= bus_i;
            if (cap_lo_i) lo_q <= bus_i[BYTE_W-1 -: LO_W];
        end
    end

    assign word_o = {hi_q, lo_q};
endmodule

// File: rtl/adc_byte_reader.sv
`timescale 1ns/1ps
module adc_byte_reader
    import adc_rd_pkg::*;
#(
    parameter int unsigned SETUP_CYC   = 10,
    parameter int unsigned PULSE_CYC   = 4,
    parameter int unsigned ACCESS_CYC  = 3,
    parameter int unsigned TIMEOUT_CYC = 4000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_req_i,
    input  logic        conv_busy_i,
    input  logic [7:0]  data_bus_i,
    output logic        chip_en_o,
    output logic        chip_sel_n_o,
    output logic        read_mode_o,
    output logic        word_mode_o,
    output logic        byte_addr_o,
    output logic [11:0] result_o,
    output logic        done_o,
    output logic        timeout_o
);
    localparam int unsigned CNT_MAX = max4(SETUP_CYC, PULSE_CYC, ACCESS_CYC, TIMEOUT_CYC);
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);

    logic          busy_s;
    logic          tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val;
    logic          cap_hi, cap_lo;
    bus_ctrl_t     ctrl;

    rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (conv_busy_i),
        .q_o (busy_s)
    );

    rd_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    rd_ctrl_fsm #(
        .SETUP_CYC   (SETUP_CYC),
        .PULSE_CYC   (PULSE_CYC),
        .ACCESS_CYC  (ACCESS_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .CW          (CW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_req_i),
        .busy_s_i   (busy_s),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .ctrl_o     (ctrl),
        .cap_hi_o   (cap_hi),
        .cap_lo_o   (cap_lo),
        .done_o     (done_o),
        .err_o      (timeout_o)
    );

    rd_word_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .cap_hi_i (cap_hi),
        .cap_lo_i (cap_lo),
        .bus_i    (data_bus_i),
        .word_o   (result_o)
    );

    assign chip_en_o    = ctrl.en;
    assign chip_sel_n_o = ctrl.sel_n;
    assign read_mode_o  = ctrl.rdconv;
    assign byte_addr_o  = ctrl.addr;
    assign word_mode_o  = 1'b0;
endmodule

// File: rtl/adc_byte_reader_chk.sv
`timescale 1ns/1ps
module adc_byte_reader_chk #(
    parameter int unsigned SETUP_CYC = 10
) (
    input logic clk,
    input logic rst,
    input logic conv_busy_i,
    input logic chip_en_o,
    input logic chip_sel_n_o,
    input logic read_mode_o,
    input logic byte_addr_o,
    input logic done_o,
    input logic timeout_o
);
    localparam int unsigned RW = $clog2(SETUP_CYC + 2) + 1;

    logic          selected;
    logic [RW-1:0] run_q;

    assign selected = chip_en_o && !chip_sel_n_o;

    always_ff @(posedge clk) begin
        if (rst || !selected) begin
            run_q <= '0;
        end else if (read_mode_o && run_q != '1) begin
            run_q <= run_q + 1'b1;
        end
    end

    AST_CONV_SELECTED: assert property (@(posedge clk) disable iff (rst)
        !read_mode_o |-> selected); // R2

    AST_SETUP_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $fell(read_mode_o) |-> (32'(run_q) >= SETUP_CYC)); // R2

    AST_ADDR_AT_START: assert property (@(posedge clk) disable iff (rst)
        $fell(read_mode_o) |-> !byte_addr_o); // R3

    AST_ADDR_STABLE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (conv_busy_i && $past(conv_busy_i)) |-> $stable(byte_addr_o)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

    AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o); // R10

    AST_DONE_XOR_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        !(done_o && timeout_o)); // R10

    AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        (done_o || timeout_o) |-> (!chip_en_o && chip_sel_n_o && read_mode_o)); // R1
endmodule

bind adc_byte_reader adc_byte_reader_chk #(.SETUP_CYC(SETUP_CYC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .conv_busy_i  (conv_busy_i),
    .chip_en_o    (chip_en_o),
    .chip_sel_n_o (chip_sel_n_o),
    .read_mode_o  (read_mode_o),
    .byte_addr_o  (byte_addr_o),
    .done_o       (done_o),
    .timeout_o    (timeout_o)
);

// File: tb/test_adc_byte_reader.sv
`timescale 1ns/1ps
module test_adc_byte_reader;
    localparam int SETUP  = 10;
    localparam int PULSE  = 4;
    localparam int ACC    = 3;
    localparam int TMO    = 300;
    localparam int SYNC   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_req = 1'b0;
    logic        busy = 1'b0;
    logic [7:0]  bus;
    logic        en, sel_n, rdc, wmode, a0, done, tmo;
    logic [11:0] result;

    always #2.5 clk = ~clk;

    adc_byte_reader #(
        .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .ACCESS_CYC(ACC),
        .TIMEOUT_CYC(TMO), .SYNC_STAGES(SYNC)
    ) i_adc_byte_reader (
        .clk(clk), .rst(rst), .start_req_i(start_req), .conv_busy_i(busy),
        .data_bus_i(bus), .chip_en_o(en), .chip_sel_n_o(sel_n), .read_mode_o(rdc),
        .word_mode_o(wmode), .byte_addr_o(a0), .result_o(result),
        .done_o(done), .timeout_o(tmo)
    );

    // converter model state
    logic [11:0] m_code = '0;
    logic [3:0]  m_pad = '0;
    int  m_busy_len = 20;
    bit  m_no_rise = 0, m_no_fall = 0, m_clear = 0;
    int  m_phase = 0, m_cnt = 0;
    int  m_starts = 0, m_min_setup = 1000000, m_setup_run = 0;
    logic m_a0_start = 1'b0;
    int  m_a0_moves = 0, m_wide = 0, m_since_fall = 0;
    int  m_done_cnt = 0, m_long_done = 0, m_tmo_cnt = 0;
    logic prev_rd = 1'b1, prev_a0 = 1'b0, prev_done = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    assign bus = (en && !sel_n && rdc && !busy) ? (a0 ? {m_code[3:0], m_pad} : m_code[11:4]) : 8'hC3;

    always @(negedge clk) begin
        if (rst) begin
            busy = 1'b0; m_phase = 0; prev_rd = 1'b1; m_setup_run = 0;
        end else begin
            m_since_fall++;
            if (en && !sel_n && rdc) m_setup_run++;
            else if (!(en && !sel_n)) m_setup_run = 0;
            if (prev_rd && !rdc && en && !sel_n) begin
                m_starts++;
                m_a0_start = a0;
                if (m_setup_run < m_min_setup) m_min_setup = m_setup_run;
                m_setup_run = 0;
                if (m_phase == 0) begin m_phase = 1; m_cnt = 2; end
            end
            if (busy && a0 != prev_a0) m_a0_moves++;
            if (wmode) m_wide++;
            if (done) begin m_done_cnt++; if (prev_done) m_long_done++; end
            if (tmo) m_tmo_cnt++;
            if (m_clear) begin
                busy = 1'b0; m_phase = 0; m_clear = 0;
            end else if (m_phase == 1) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    if (m_no_rise) m_phase = 0;
                    else begin busy = 1'b1; m_phase = 2; m_cnt = m_busy_len; end
                end
            end else if (m_phase == 2 && !m_no_fall) begin
                m_cnt--;
                if (m_cnt == 0) begin busy = 1'b0; m_phase = 0; m_since_fall = 0; end
            end
            prev_rd = rdc; prev_a0 = a0; prev_done = done;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #0.5;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        #0.5;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) tick();
        rst = 1'b0;
        tick();
        check(!en && sel_n && rdc && !a0, "R1 idle controls", {en, sel_n, rdc, a0}, 4'b0110);
        check(!done && !tmo, "R1 no pulses", {done, tmo}, 0);
        check(result == 12'h000, "R1 result reset", result, 0);
        check(!wmode, "R4 word mode low", wmode, 0);
    endtask

    task automatic t_transfer(input logic [11:0] code, input logic [3:0] pad, input int blen);
        int s0, d0, waited;
        logic [11:0] got;
        m_code = code; m_pad = pad; m_busy_len = blen;
        s0 = m_starts; d0 = m_done_cnt; waited = 0;
        pulse_start();
        while (!done && !tmo && waited < 5000) begin tick(); waited++; end
        got = result;
        check(done == 1'b1, "R8 done reached", done, 1);
        check(got[11:4] == code[11:4], "R5 upper byte", got[11:4], code[11:4]);
        check(got[3:0] == code[3:0], "R6 low nibble, padding ignored", got[3:0], code[3:0]);
        check(m_starts == s0 + 1, "R2 one start edge", m_starts - s0, 1);
        check(m_min_setup >= SETUP, "R2 setup window", m_min_setup, SETUP);
        check(m_a0_start == 1'b0, "R3 A0 low at start", m_a0_start, 0);
        check(m_since_fall == SYNC + 1 + 2 * ACC, "R7 read latency", m_since_fall, SYNC + 1 + 2 * ACC);
        tick();
        check(!done, "R8 single-cycle done", done, 0);
        check(result == got, "R8 result held", result, got);
        check(m_done_cnt == d0 + 1 && m_long_done == 0, "R8 one pulse", m_done_cnt - d0, 1);
        check(!en && sel_n && rdc && !a0, "R1 idle after done", {en, sel_n, rdc, a0}, 4'b0110);
        check(m_a0_moves == 0, "R3 A0 stable while busy", m_a0_moves, 0);
        check(m_wide == 0, "R4 word mode never high", m_wide, 0);
    endtask

    task automatic t_ignore_busy_request();
        int s0, d0, waited;
        m_code = 12'h9E1; m_pad = 4'hB; m_busy_len = 60;
        s0 = m_starts; d0 = m_done_cnt; waited = 0;
        pulse_start();
        repeat (30) tick();
        check(busy == 1'b1, "R9 request lands during busy", busy, 1);
        pulse_start();
        while (!done && waited < 5000) begin tick(); waited++; end
        check(result == 12'h9E1, "R9 result after ignored request", result, 12'h9E1);
        repeat (40) tick();
        check(m_starts == s0 + 1, "R9 no extra conversion", m_starts - s0, 1);
        check(m_done_cnt == d0 + 1, "R9 no extra done", m_done_cnt - d0, 1);
    endtask

    task automatic t_timeout(input bit no_rise);
        int d0, t0, waited;
        m_no_rise = no_rise; m_no_fall = !no_rise; m_busy_len = 10;
        d0 = m_done_cnt; t0 = m_tmo_cnt; waited = 0;
        pulse_start();
        while (!tmo && waited < 2000) begin tick(); waited++; end
        check(tmo == 1'b1, no_rise ? "R10 timeout, no rise" : "R10 timeout, no fall", tmo, 1);
        check(waited >= TMO, "R10 budget respected", waited, TMO);
        tick();
        check(!tmo && m_tmo_cnt == t0 + 1, "R10 single timeout pulse", m_tmo_cnt - t0, 1);
        check(m_done_cnt == d0, "R10 no done on fault", m_done_cnt - d0, 0);
        check(!en && sel_n && rdc && !a0, "R1 idle after timeout", {en, sel_n, rdc, a0}, 4'b0110);
        m_no_rise = 0; m_no_fall = 0; m_clear = 1;
        repeat (3) tick();
        t_transfer(12'h71D, 4'h9, 25);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_transfer(12'h000, 4'hF, 20);
        t_transfer(12'hFFF, 4'h0, 35);
        t_transfer(12'h800, 4'hA, 50);
        t_transfer(12'h5A3, 4'h7, 120);
        t_transfer(12'h3C6, 4'h5, 3);
        t_ignore_busy_request();
        t_timeout(1'b1);
        t_timeout(1'b0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule